// File: doc/BRIEF.md
# Pipelined Floating-Point Multiplier

This block multiplies two 16-bit floating-point numbers in a three-stage pipeline. It accepts one operand pair per clock when `en_i` is high. It returns the packed product together with a 4-bit status code three clock edges later, and `vld_o` marks that cycle.

Stage one screens out zero operands and unpacks the fields, adding the hidden leading one to each mantissa. Stage two does three things: it forms the product sign, it adds the exponents in a field two bits wider than the stored exponent, and it multiplies the mantissas. Each of these three parts raises its own completion flag. Stage three packs a product only when all three flags are set. When packing, it normalizes by at most one place, truncates the fraction, and reads overflow and underflow from the extended exponent.

Rounding beyond truncation is not handled. NaN, infinity and denormal inputs are not handled.

Top module: `fmul_pipe`

## Requirements
- R1: The operand and result format places the sign in bit 15, a biased exponent (bias 127) in bits 14:7 and the fraction in bits 6:0. An operand whose exponent field is zero is treated as zero.
- R2: A pair sampled with `en_i` high at a rising edge appears on `res_o`/`stat_o` after the third rising edge, with `vld_o` high in that cycle only. A new pair may be issued on every cycle.
- R3: If either operand is zero, the result is 16'h0000 and the status is 4'b0100.
- R4: For a packed product, the sign bit of a nonzero result is the XOR of the operand signs.
- R5: For nonzero operands, the exponent is ea+eb-127. The 8-bit mantissas, each with its hidden one, are multiplied to a 16-bit product. If product bit 15 is set, the exponent is incremented and the fraction is product bits 14:8; otherwise the fraction is product bits 13:7 (truncation).
- R6: If the final exponent is 255 or more, the status is 4'b0001 and the result is the sign followed by exponent 8'hFF and fraction 0.
- R7: If the final exponent is 0 or less, the status is 4'b0010 and the result is 16'h0000.
- R8: A product with a final exponent from 1 to 254 has status 4'b0000.
- R9: A cycle with `en_i` low produces `vld_o` low three edges later and leaves `res_o` and `stat_o` unchanged.
- R10: While reset is active, `vld_o`, `res_o` and `stat_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Operand pair valid / enable |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| res_o | output | 16 | Packed product |
| stat_o | output | 4 | Status: 0000 normal, 0001 overflow, 0010 underflow, 0100 zero |
| vld_o | output | 1 | Result valid |

## Verification
Products of 1.0 by 1.0 are set against 1.5 by 1.5 to separate the case without a shift from the case with a one-place normalizing shift. Mixed signs confirm that the sign is the XOR and not copied from one operand. The exponent boundaries are probed on each side: 254 against 255, the latter reached both directly and through the normalizing increment, and 1 against 0. These show whether overflow and underflow are decided before or after normalization. A back-to-back stream with zeros mixed in, followed by idle cycles, separates correct per-cycle issue and result hold from stale or shifted pipeline data.

// File: rtl/fmul_pkg.sv
package fmul_pkg;
  localparam int DEF_EXP_W = 8;
  localparam int DEF_FRC_W = 7;

  typedef enum logic [3:0] {
    ST_OK   = 4'b0000,
    ST_OVF  = 4'b0001,
    ST_UNF  = 4'b0010,
    ST_ZERO = 4'b0100
  } fmul_stat_e;
endpackage

// File: rtl/fmul_unpack.sv
module fmul_unpack #(
  parameter int EXP_W = 8,
  parameter int FRC_W = 7,
  localparam int W  = 1 + EXP_W + FRC_W,
  localparam int MW = FRC_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  output logic             v_o,
  output logic             zero_o,
  output logic             sa_o,
  output logic             sb_o,
  output logic [EXP_W-1:0] ea_o,
  output logic [EXP_W-1:0] eb_o,
  output logic [MW-1:0]    ma_o,
  output logic [MW-1:0]    mb_o
);
  function automatic logic is_zero(input logic [W-1:0] x);
    return (x[W-2 -: EXP_W] == '0);
  endfunction

  logic any_zero;
  assign any_zero = is_zero(a_i) || is_zero(b_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o    <= 1'b0;
      zero_o <= 1'b0;
      sa_o   <= 1'b0;
      sb_o   <= 1'b0;
      ea_o   <= '0;
      eb_o   <= '0;
      ma_o   <= '0;
      mb_o   <= '0;
    end else begin
      v_o    <= en_i;
      zero_o <= en_i && any_zero;
      if (en_i && !any_zero) begin
        sa_o <= a_i[W-1];
        sb_o <= b_i[W-1];
        ea_o <= a_i[W-2 -: EXP_W];
        eb_o <= b_i[W-2 -: EXP_W];
        ma_o <= {1'b1, a_i[FRC_W-1:0]};
        mb_o <= {1'b1, b_i[FRC_W-1:0]};
      end else begin
        sa_o <= 1'b0;
        sb_o <= 1'b0;
        ea_o <= '0;
        eb_o <= '0;
        ma_o <= '0;
        mb_o <= '0;
      end
    end
  end
endmodule

// File: rtl/fmul_core.sv
module fmul_core #(
  parameter int EXP_W = 8,
  parameter int FRC_W = 7,
  localparam int MW   = FRC_W + 1,
  localparam int PW   = 2 * MW,
  localparam int XW   = EXP_W + 2,
  localparam int BIAS = (1 << (EXP_W - 1)) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             v_i,
  input  logic             zero_i,
  input  logic             sa_i,
  input  logic             sb_i,
  input  logic [EXP_W-1:0] ea_i,
  input  logic [EXP_W-1:0] eb_i,
  input  logic [MW-1:0]    ma_i,
  input  logic [MW-1:0]    mb_i,
  output logic             v_o,
  output logic             zero_o,
  output logic             sgn_o,
  output logic             sgn_flg_o,
  output logic [XW-1:0]    exp_o,
  output logic             exp_flg_o,
  output logic [PW-1:0]    prod_o,
  output logic             mant_flg_o
);
  function automatic logic [XW-1:0] exp_sum(input logic [EXP_W-1:0] x,
                                            input logic [EXP_W-1:0] y);
    logic [XW-1:0] xe, ye;
    xe = {2'b00, x};
    ye = {2'b00, y};
    return xe + ye - XW'(BIAS);
  endfunction

  function automatic logic [PW-1:0] mant_mul(input logic [MW-1:0] x,
                                             input logic [MW-1:0] y);
    return PW'(x) * PW'(y);
  endfunction

  logic do_calc;
  assign do_calc = v_i && !zero_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o        <= 1'b0;
      zero_o     <= 1'b0;
      sgn_o      <= 1'b0;
      sgn_flg_o  <= 1'b0;
      exp_o      <= '0;
      exp_flg_o  <= 1'b0;
      prod_o     <= '0;
      mant_flg_o <= 1'b0;
    end else begin
      v_o        <= v_i;
      zero_o     <= v_i && zero_i;
      sgn_o      <= sa_i ^ sb_i;
      sgn_flg_o  <= v_i;
      exp_flg_o  <= do_calc;
      mant_flg_o <= do_calc;
      exp_o      <= do_calc ? exp_sum(ea_i, eb_i) : '0;
      prod_o     <= do_calc ? mant_mul(ma_i, mb_i) : '0;
    end
  end
endmodule

// File: rtl/fmul_pack.sv
module fmul_pack
  import fmul_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int FRC_W = 7,
  localparam int W    = 1 + EXP_W + FRC_W,
  localparam int MW   = FRC_W + 1,
  localparam int PW   = 2 * MW,
  localparam int XW   = EXP_W + 2,
  localparam int EMAX = (1 << EXP_W) - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          v_i,
  input  logic          zero_i,
  input  logic          sgn_i,
  input  logic          sgn_flg_i,
  input  logic [XW-1:0] exp_i,
  input  logic          exp_flg_i,
  input  logic [PW-1:0] prod_i,
  input  logic          mant_flg_i,
  output logic [W-1:0]  res_o,
  output logic [3:0]    stat_o,
  output logic          vld_o
);
  function automatic logic [FRC_W-1:0] norm_frac(input logic [PW-1:0] p);
    return p[PW-1] ? p[PW-2 -: FRC_W] : p[PW-3 -: FRC_W];
  endfunction

  function automatic logic [XW-1:0] norm_exp(input logic [XW-1:0] e,
                                             input logic [PW-1:0] p);
    return e + XW'(p[PW-1]);
  endfunction

  logic          all_flg;
  logic [XW-1:0] e_fin;
  logic          unf, ovf;
  logic [W-1:0]  res_d;
  fmul_stat_e    stat_d;

  assign all_flg = sgn_flg_i && exp_flg_i && mant_flg_i;
  assign e_fin   = norm_exp(exp_i, prod_i);
  assign unf     = e_fin[XW-1] || (e_fin == '0);
  assign ovf     = !e_fin[XW-1] && (e_fin >= XW'(EMAX));

  always_comb begin
    res_d  = '0;
    stat_d = ST_ZERO;
    if (!zero_i && all_flg) begin
      if (unf) begin
        stat_d = ST_UNF;
      end else if (ovf) begin
        stat_d = ST_OVF;
        res_d  = {sgn_i, {EXP_W{1'b1}}, {FRC_W{1'b0}}};
      end else begin
        stat_d = ST_OK;
        res_d  = {sgn_i, e_fin[EXP_W-1:0], norm_frac(prod_i)};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_o  <= '0;
      stat_o <= 4'b0000;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= v_i;
      if (v_i) begin
        res_o  <= res_d;
        stat_o <= stat_d;
      end
    end
  end
endmodule

// File: rtl/fmul_pipe.sv
module fmul_pipe
  import fmul_pkg::*;
#(
  parameter int EXP_W = DEF_EXP_W,
  parameter int FRC_W = DEF_FRC_W,
  localparam int W    = 1 + EXP_W + FRC_W,
  localparam int MW   = FRC_W + 1,
  localparam int PW   = 2 * MW,
  localparam int XW   = EXP_W + 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o,
  output logic [3:0]   stat_o,
  output logic         vld_o
);
  logic             s1_valid, s1_zero, s1_sa, s1_sb;
  logic [EXP_W-1:0] s1_ea, s1_eb;
  logic [MW-1:0]    s1_ma, s1_mb;

  logic             s2_valid, s2_zero, s2_sign;
  logic             sign_flag, exp_flag, mant_flag;
  logic [XW-1:0]    s2_exp;
  logic [PW-1:0]    s2_prod;

  fmul_unpack #(.EXP_W(EXP_W), .FRC_W(FRC_W)) u_st1 (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .a_i(a_i), .b_i(b_i),
    .v_o(s1_valid), .zero_o(s1_zero), .sa_o(s1_sa), .sb_o(s1_sb),
    .ea_o(s1_ea), .eb_o(s1_eb), .ma_o(s1_ma), .mb_o(s1_mb)
  );

  fmul_core #(.EXP_W(EXP_W), .FRC_W(FRC_W)) u_st2 (
    .clk(clk), .rst_n(rst_n), .v_i(s1_valid), .zero_i(s1_zero),
    .sa_i(s1_sa), .sb_i(s1_sb), .ea_i(s1_ea), .eb_i(s1_eb),
    .ma_i(s1_ma), .mb_i(s1_mb),
    .v_o(s2_valid), .zero_o(s2_zero), .sgn_o(s2_sign), .sgn_flg_o(sign_flag),
    .exp_o(s2_exp), .exp_flg_o(exp_flag), .prod_o(s2_prod), .mant_flg_o(mant_flag)
  );

  fmul_pack #(.EXP_W(EXP_W), .FRC_W(FRC_W)) u_st3 (
    .clk(clk), .rst_n(rst_n), .v_i(s2_valid), .zero_i(s2_zero),
    .sgn_i(s2_sign), .sgn_flg_i(sign_flag), .exp_i(s2_exp), .exp_flg_i(exp_flag),
    .prod_i(s2_prod), .mant_flg_i(mant_flag),
    .res_o(res_o), .stat_o(stat_o), .vld_o(vld_o)
  );
endmodule

// File: rtl/fmul_pipe_chk.sv
module fmul_pipe_chk #(
  parameter int EXP_W = 8,
  parameter int FRC_W = 7,
  localparam int W = 1 + EXP_W + FRC_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en_i,
  input logic [W-1:0] res_o,
  input logic [3:0]   stat_o,
  input logic         vld_o,
  input logic         s2_valid,
  input logic         s2_zero,
  input logic         sign_flag,
  input logic         exp_flag,
  input logic         mant_flag
);
  logic [2:0] en_hist;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_hist <= '0;
    else        en_hist <= {en_hist[1:0], en_i};
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o == en_hist[2]); // R2

  AST_FLAGS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && !s2_zero) |-> (sign_flag && exp_flag && mant_flag)); // R5

  AST_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && s2_zero) |=> (vld_o && stat_o == 4'b0100 && res_o == '0)); // R3

  AST_STAT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> $onehot0(stat_o)); // R8

  AST_OVF_PACK: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && stat_o == 4'b0001) |-> (res_o[W-2 -: EXP_W] == '1 && res_o[FRC_W-1:0] == '0)); // R6

  AST_UNF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && stat_o == 4'b0010) |-> (res_o == '0)); // R7

  AST_NORMAL_EXP: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && stat_o == 4'b0000) |-> (res_o[W-2 -: EXP_W] != '0 && res_o[W-2 -: EXP_W] != '1)); // R8

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !s2_valid |=> ($stable(res_o) && $stable(stat_o))); // R9
endmodule

bind fmul_pipe fmul_pipe_chk #(.EXP_W(EXP_W), .FRC_W(FRC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .res_o(res_o), .stat_o(stat_o),
  .vld_o(vld_o), .s2_valid(s2_valid), .s2_zero(s2_zero),
  .sign_flag(sign_flag), .exp_flag(exp_flag), .mant_flag(mant_flag)
);

// File: tb/fmul_pipe_bench.sv
`timescale 1ns/1ps
module fmul_pipe_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_i = 1'b0;
  logic [15:0] a_i = '0;
  logic [15:0] b_i = '0;
  logic [15:0] res_o;
  logic [3:0]  stat_o;
  logic        vld_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  fmul_pipe u_fmul_pipe (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .a_i(a_i), .b_i(b_i),
    .res_o(res_o), .stat_o(stat_o), .vld_o(vld_o)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  // Integer reference: {status, result}
  function automatic logic [19:0] model(input logic [15:0] a, input logic [15:0] b);
    int ea, eb, e, p, f;
    logic s;
    ea = int'(a[14:7]);
    eb = int'(b[14:7]);
    s  = a[15] ^ b[15];
    if (ea == 0 || eb == 0) return {4'b0100, 16'h0000};
    p = (128 + int'(a[6:0])) * (128 + int'(b[6:0]));
    e = ea + eb - 127;
    if (p >= 32768) begin e = e + 1; f = (p / 256) % 128; end
    else            f = (p / 128) % 128;
    if (e <= 0)   return {4'b0010, 16'h0000};
    if (e >= 255) return {4'b0001, s, 8'hFF, 7'h00};
    return {4'b0000, s, 8'(e), 7'(f)};
  endfunction

  task automatic run_op(input string req, input logic [15:0] a, input logic [15:0] b,
                        input logic [15:0] er, input logic [3:0] es);
    @(negedge clk);
    a_i = a; b_i = b; en_i = 1'b1;
    @(negedge clk);
    en_i = 1'b0;
    @(negedge clk);
    check({req, " vld early (R2)"}, 32'(vld_o), 32'd0);
    @(negedge clk);
    check({req, " vld (R2)"}, 32'(vld_o), 32'd1);
    check({req, " result"}, 32'(res_o), 32'(er));
    check({req, " status"}, 32'(stat_o), 32'(es));
    check({req, " model agrees"}, 32'(model(a, b)), {12'h0, es, er});
    @(negedge clk);
    check({req, " vld single (R2)"}, 32'(vld_o), 32'd0);
  endtask

  task automatic t_reset();
    check("R10 vld in reset", 32'(vld_o), 32'd0);
    check("R10 res in reset", 32'(res_o), 32'd0);
    check("R10 stat in reset", 32'(stat_o), 32'd0);
  endtask

  task automatic t_zero();
    run_op("R3 a zero", 16'h0000, 16'h3F80, 16'h0000, 4'b0100);
    run_op("R3 b zero", 16'h4040, 16'h0000, 16'h0000, 4'b0100);
    run_op("R3 neg zero", 16'h8000, 16'hC000, 16'h0000, 4'b0100);
    run_op("R1 exp field zero counts as zero", 16'h007F, 16'h3F80, 16'h0000, 4'b0100);
  endtask

  task automatic t_normal();
    run_op("R5 one times one", 16'h3F80, 16'h3F80, 16'h3F80, 4'b0000);
    run_op("R5 shift 1.5x1.5", 16'h3FC0, 16'h3FC0, 16'h4010, 4'b0000);
    run_op("R5 truncate", 16'h3FFF, 16'h3FFF, 16'h407E, 4'b0000);
    run_op("R8 2x3", 16'h4000, 16'h4040, 16'h40C0, 4'b0000);
  endtask

  task automatic t_sign();
    run_op("R4 neg x pos", 16'hBF80, 16'h4000, 16'hC000, 4'b0000);
    run_op("R4 pos x neg", 16'h4000, 16'hBFC0, 16'hC040, 4'b0000);
    run_op("R4 neg x neg", 16'hC000, 16'hC000, 16'h4080, 4'b0000);
  endtask

  task automatic t_limits();
    run_op("R8 exp 254", 16'h7F00, 16'h3F80, 16'h7F00, 4'b0000);
    run_op("R6 exp 255", 16'h7F00, 16'hC000, 16'hFF80, 4'b0001);
    run_op("R6 via norm", 16'h7F40, 16'h3FC0, 16'h7F80, 4'b0001);
    run_op("R6 large", 16'h7F00, 16'h7F00, 16'h7F80, 4'b0001);
    run_op("R8 exp 1", 16'h0080, 16'h3F80, 16'h0080, 4'b0000);
    run_op("R7 exp 0", 16'h0080, 16'hBF00, 16'h0000, 4'b0010);
    run_op("R7 deep", 16'h0080, 16'h0080, 16'h0000, 4'b0010);
  endtask

  task automatic t_stream();
    logic [15:0] sa [8] = '{16'h3F80, 16'h0000, 16'h4040, 16'hC0A0,
                            16'h7F00, 16'h0080, 16'h3FC0, 16'h4120};
    logic [15:0] sb [8] = '{16'h4000, 16'h4000, 16'h3FC0, 16'h4170,
                            16'h4100, 16'h3E00, 16'hBFC0, 16'h0000};
    for (int t = 0; t < 11; t++) begin
      @(negedge clk);
      if (t >= 3) begin
        logic [19:0] m;
        m = model(sa[t-3], sb[t-3]);
        check("R2 stream vld", 32'(vld_o), 32'd1);
        check("R2 stream result", 32'(res_o), 32'(m[15:0]));
        check("R2 stream status", 32'(stat_o), 32'(m[19:16]));
      end
      if (t < 8) begin a_i = sa[t]; b_i = sb[t]; en_i = 1'b1; end
      else en_i = 1'b0;
    end
  endtask

  task automatic t_hold();
    logic [15:0] r0;
    logic [3:0]  s0;
    run_op("R9 setup", 16'h4040, 16'h4040, 16'h4110, 4'b0000);
    r0 = res_o; s0 = stat_o;
    @(negedge clk);
    a_i = 16'h0000; b_i = 16'h7F00; en_i = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R9 idle vld", 32'(vld_o), 32'd0);
      check("R9 idle res held", 32'(res_o), 32'(r0));
      check("R9 idle stat held", 32'(stat_o), 32'(s0));
    end
  endtask

  initial begin
    #3000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_zero();
    t_normal();
    t_sign();
    t_limits();
    t_stream();
    t_hold();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule